// File: doc/BRIEF.md
# Seven-to-one serializing pixel link transmitter

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Each word carries 24 colour bits (8 red, 8 green, 8 blue) and 4 timing bits: line sync, frame sync, data enable and one spare control bit. Every pixel clock cycle, one whole word is captured and sent, seven bits on each lane. At a 40 MHz pixel rate, each lane therefore runs at 280 Mbit/s. The pixel clock may run between 20 and 40 MHz.

All logic runs on one fast bit clock at seven times the pixel rate. The pixel clock is sampled in the bit-clock domain, and its falling edge starts each word. The fifth lane sends a fixed seven-slot pattern in step with the data slots, so the receiver can recover both the word boundary and the slot timing.

An active-low power-down input and a settling counter gate a single output-enable signal. The counter stands in for the lock time of the clock multiplier, which is 10 ms in hardware. While the enable is low, every lane output is held at zero. Downstream pad logic treats a low enable as high impedance.

Top module: `pixel_link_tx`

## Requirements
- R1: While `rst` is high, `tx_oe`, `tx_data` and `tx_clk_lane` are all 0.
- R2: The word sent is the value of `pix_word` at the falling edge of `pix_clk`. Changes to `pix_word` before that edge, or after the bit-clock edge that follows it, do not change the bits sent.
- R3: Lane L (bit L of `tx_data`) carries input bits 7L to 7L+6. Lane 0 takes bits 0 to 6 and lane 3 takes bits 21 to 27.
- R4: Each lane sends its lowest-index bit first. Slot 0 appears after the second rising `bit_clk` edge that follows the falling edge of `pix_clk`. Slot s appears s edges later, for s from 0 to 6.
- R5: `tx_clk_lane` sends the slot pattern 1,1,0,0,0,1,1 for slots 0 to 6, aligned with the data slots of each word.
- R6: When the `pix_clk` period is exactly seven `bit_clk` periods, successive words go out back to back, with no idle slot between them.
- R7: When `pd_n` is sampled low, `tx_oe` is 0 after that edge. While `tx_oe` is 0, all lane outputs, including the clock lane, stay at 0.
- R8: `tx_oe` rises at the SETTLE_CYCLES-th consecutive `bit_clk` edge that samples `pd_n` high after reset or after power-down. A low sample of `pd_n` restarts the count.
- R9: If no further falling edge arrives, the data lanes send 0 once slot 6 has gone out. The clock lane keeps repeating its pattern in the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock; its falling edge marks a new word |
| pix_word | input | 28 | Parallel word: 24 colour bits and 4 timing bits |
| pd_n | input | 1 | Active-low power-down |
| tx_data | output | 4 | Serial data, one bit per lane |
| tx_clk_lane | output | 1 | Forwarded clock lane |
| tx_oe | output | 1 | Output enable; low models high impedance |

## Verification
A table of words covers several cases: all zeros, all ones, two alternating patterns, a word that fills only lane 0, a word with only the end bits set, a word with one bit per lane, and a mixed word. Words that fill a single lane, or set one bit per lane, expose swapped lanes or reversed slot order. Alternating patterns expose an off-by-one slot error. The table is streamed back to back, which checks the word boundary and the drain to zero after the last word. It is then streamed again with `pix_word` set wrong outside a narrow window around the falling edge, which shows that capture happens on that edge and not on the rising one. Directed tests then measure the settling count after reset, the clock lane held silent during power-down, and the restart of the count after a short power-down pulse.

// File: rtl/pixel_link_pkg.sv
package pixel_link_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_SLOTS = 7;
  localparam logic [6:0]  DEF_CLK_PATTERN = 7'b1100011; // slot 0 at bit 0
  localparam int unsigned DEF_SETTLE_CYCLES = 2_800_000; // 10 ms at 280 MHz

  typedef enum logic [0:0] {
    GATE_WAIT = 1'b0,
    GATE_LIVE = 1'b1
  } gate_state_e;
endpackage

// File: rtl/pixel_link_capture.sv
module pixel_link_capture #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] pix_word,
  output logic              load,
  output logic [WORD_W-1:0] word_q
);
  logic pclk_now;
  logic pclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_now  <= 1'b0;
      pclk_prev <= 1'b0;
      word_q    <= '0;
    end else begin
      pclk_now  <= pix_clk;
      pclk_prev <= pclk_now;
      word_q    <= pix_word;
    end
  end

  // the word in word_q was sampled on the first edge that saw the low level
  assign load = pclk_prev & ~pclk_now;

  assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/pixel_link_lane.sv
module pixel_link_lane #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SLOTS-1:0] par,
  output logic             ser
);
  logic [SLOTS-2:0] rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser  <= 1'b0;
      rest <= '0;
    end else if (load) begin
      ser  <= par[0];
      rest <= par[SLOTS-1:1];
    end else begin
      ser  <= rest[0];
      rest <= rest >> 1;
    end
  end

  assert_first_slot_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> ser == $past(par[0]));
endmodule

// File: rtl/pixel_link_clkgen.sv
module pixel_link_clkgen #(
  parameter int unsigned     SLOTS   = 7,
  parameter logic [SLOTS-1:0] PATTERN = 7'b1100011
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic clk_lane
);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_lane <= 1'b0;
      slot     <= '0;
    end else if (load) begin
      clk_lane <= PATTERN[0];
      slot     <= SLOT_W'(1);
    end else begin
      clk_lane <= PATTERN[slot];
      slot     <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + SLOT_W'(1);
    end
  end

  assert_word_start_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> clk_lane == PATTERN[0] && slot == SLOT_W'(1));
endmodule

// File: rtl/pixel_link_settle.sv
module pixel_link_settle #(
  parameter int unsigned SETTLE_CYCLES = 2_800_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic oe
);
  import pixel_link_pkg::*;

  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);

  gate_state_e      state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      state <= GATE_WAIT;
      cnt   <= '0;
      oe    <= 1'b0;
    end else begin
      case (state)
        GATE_WAIT: begin
          if (cnt == CNT_W'(SETTLE_CYCLES - 1)) begin
            state <= GATE_LIVE;
            oe    <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= GATE_LIVE;
          oe    <= 1'b1;
        end
      endcase
    end
  end

  assert_pd_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> !oe);
  assert_rise_after_count_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(pd_n) && $past(cnt) == CNT_W'(SETTLE_CYCLES - 1));
  assert_hold_while_up_R8: assert property (@(posedge clk) disable iff (rst)
    oe && pd_n |=> oe);
endmodule

// File: rtl/pixel_link_tx.sv
module pixel_link_tx #(
  parameter int unsigned      LANES         = pixel_link_pkg::DEF_LANES,
  parameter int unsigned      SLOTS         = pixel_link_pkg::DEF_SLOTS,
  parameter logic [SLOTS-1:0] CLK_PATTERN   = pixel_link_pkg::DEF_CLK_PATTERN,
  parameter int unsigned      SETTLE_CYCLES = pixel_link_pkg::DEF_SETTLE_CYCLES
) (
  input  logic                   bit_clk,
  input  logic                   rst,
  input  logic                   pix_clk,
  input  logic [LANES*SLOTS-1:0] pix_word,
  input  logic                   pd_n,
  output logic [LANES-1:0]       tx_data,
  output logic                   tx_clk_lane,
  output logic                   tx_oe
);
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic              load;
  logic [WORD_W-1:0] word_q;
  logic [LANES-1:0]  lane_bits;
  logic              clk_bit;
  logic              oe;

  pixel_link_capture #(.WORD_W(WORD_W)) u_capture (
    .clk      (bit_clk),
    .rst      (rst),
    .pix_clk  (pix_clk),
    .pix_word (pix_word),
    .load     (load),
    .word_q   (word_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pixel_link_lane #(.SLOTS(SLOTS)) u_lane (
      .clk  (bit_clk),
      .rst  (rst),
      .load (load),
      .par  (word_q[l*SLOTS +: SLOTS]),
      .ser  (lane_bits[l])
    );
  end

  pixel_link_clkgen #(.SLOTS(SLOTS), .PATTERN(CLK_PATTERN)) u_clkgen (
    .clk      (bit_clk),
    .rst      (rst),
    .load     (load),
    .clk_lane (clk_bit)
  );

  pixel_link_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk  (bit_clk),
    .rst  (rst),
    .pd_n (pd_n),
    .oe   (oe)
  );

  assign tx_data     = lane_bits & {LANES{oe}};
  assign tx_clk_lane = clk_bit & oe;
  assign tx_oe       = oe;

  assert_quiet_when_off_R7: assert property (@(posedge bit_clk) disable iff (rst)
    !pd_n |=> tx_data == '0 && !tx_clk_lane);
endmodule

// File: tb/pixel_link_tx_test.sv
module pixel_link_tx_test;
  localparam int unsigned SETTLE = 20;
  localparam logic [6:0]  PAT    = 7'b1100011;

  localparam logic [27:0] STIM [8] = '{
    28'h0000000, 28'hFFFFFFF, 28'h5555555, 28'hAAAAAAA,
    28'h000007F, 28'h8000001, 28'h0204081, 28'h1234567
  };

  logic        bit_clk = 1'b0;
  logic        rst     = 1'b1;
  logic        pix_clk = 1'b1;
  logic [27:0] pix_word = '0;
  logic        pd_n    = 1'b1;
  logic [3:0]  tx_data;
  logic        tx_clk_lane;
  logic        tx_oe;

  int tests = 0;
  int fails = 0;
  logic [27:0] plan_w [8];
  int plan_n = 0;

  always #4 bit_clk = ~bit_clk;

  pixel_link_tx #(.SETTLE_CYCLES(SETTLE)) uut (
    .bit_clk(bit_clk), .rst(rst), .pix_clk(pix_clk), .pix_word(pix_word),
    .pd_n(pd_n), .tx_data(tx_data), .tx_clk_lane(tx_clk_lane), .tx_oe(tx_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_of(input logic [27:0] w, input int s);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = w[7*l + s];
    return r;
  endfunction

  // streams plan_w back to back, seven bit clocks per pixel clock
  task automatic stream(input bit wrong_outside);
    for (int cnt = 0; cnt < 7*plan_n + 13; cnt++) begin
      int p, ph;
      @(negedge bit_clk);
      p  = cnt / 7;
      ph = cnt % 7;
      if (cnt >= 6) begin
        int m, idx, s;
        m = cnt - 6; idx = m / 7; s = m % 7;
        if (idx < plan_n) begin
          check(wrong_outside ? "R2 data" : (idx == 0 ? "R3 R4 data" : "R6 data"),
                int'(tx_data), int'(lanes_of(plan_w[idx], s)));
          check("R5 clock lane", int'(tx_clk_lane), int'(PAT[s]));
        end else if (idx == plan_n) begin
          check("R9 drain", int'(tx_data), 0);
          check("R9 clock free-run", int'(tx_clk_lane), int'(PAT[s]));
        end
      end
      if (p < plan_n) begin
        case (ph)
          0: begin pix_clk = 1'b1; pix_word = wrong_outside ? ~plan_w[p] : plan_w[p]; end
          3: pix_word = plan_w[p];
          4: pix_clk = 1'b0;
          5: if (wrong_outside) pix_word = ~plan_w[p];
          default: ;
        endcase
      end else begin
        pix_clk = 1'b1;
      end
    end
  endtask

  // release power-down and count samples until enable rises
  task automatic settle_count(input string tag);
    for (int k = 1; k <= SETTLE; k++) begin
      @(negedge bit_clk);
      if (k == SETTLE - 1) check({tag, " still low"}, int'(tx_oe), 0);
      if (k == SETTLE)     check({tag, " rises"}, int'(tx_oe), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge bit_clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge bit_clk);
    check("R1 oe", int'(tx_oe), 0);
    check("R1 data", int'(tx_data), 0);
    check("R1 clock lane", int'(tx_clk_lane), 0);

    // R8: settling after reset
    rst = 1'b0;
    settle_count("R8 after reset");

    // table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < 8; i++) plan_w[i] = STIM[i];
    plan_n = 8;
    stream(1'b0);
    // R2: word correct only around the falling edge
    stream(1'b1);

    // R7: power-down silences all lanes
    pd_n = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge bit_clk);
      check("R7 oe", int'(tx_oe), 0);
      check("R7 clock lane", int'(tx_clk_lane), 0);
    end
    // R8: short release then a low pulse restarts the count
    pd_n = 1'b1;
    repeat (5) @(negedge bit_clk);
    check("R8 partial count", int'(tx_oe), 0);
    pd_n = 1'b0;
    @(negedge bit_clk);
    pd_n = 1'b1;
    settle_count("R8 restart");

    // one more word after restart
    plan_w[0] = 28'h0F0F0F3;
    plan_n = 1;
    stream(1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule